// File: doc/BRIEF.md
# Dual-Priority Interrupt Control Register

This block is the interrupt control and status register of a small microcontroller core. One 8-bit register, which software can read and write, holds an enable bit and a flag bit for each of three sources: a timer overflow, an external event, and a change detector that watches four input port pins. The two top bits are global enables, and their meaning depends on a priority-mode input that is held outside the register. The block drives two request lines toward the core, a high-priority line and a low-priority line.

Each flag is set when its event occurs, whatever the enables hold, so software can poll the flags. Software clears a flag by writing 0 to it. The port-change flag is different. It keeps being set for as long as the synchronized pins differ from the value last captured by a port read. A software clear therefore has no lasting effect until the port has been read.

Top module: `irq_ctl_reg`

## Requirements
- R1: After reset the register reads 0x00. Bits 7..1 are always 0 at reset, and the port-change flag (bit 0) takes the parameter value `CHG_FLAG_RST`, which defaults to 0. Both request outputs are 0.
- R2: A write loads all eight bits, and the new value is readable on `rd_data_o` after the clock edge that accepts the write. The bit map is: 7 global/high enable, 6 peripheral/low enable, 5 timer enable, 4 external enable, 3 port-change enable, 2 timer flag, 1 external flag, 0 port-change flag.
- R3: A one-cycle `tmr_ovf_i` pulse sets bit 2 at the next edge, whatever the enable bits hold. The bit then stays set until a write of 0 clears it.
- R4: A one-cycle `ext_evt_i` pulse sets bit 1 at the next edge, whatever the enable bits hold. The bit then stays set until a write of 0 clears it.
- R5: When a flag's set event and a software write of 0 to that flag fall in the same cycle, the flag ends up 1.
- R6: The four pins pass through a two-stage synchronizer. A pin change that is stable before edge N sets bit 0 after edge N+2 and not earlier.
- R7: While the synchronized pins differ from the captured value, bit 0 is set again on every cycle, so a write of 0 does not stick. A `port_rd_i` strobe captures the synchronized pins. Bit 0 is still 1 after that edge, and a later write of 0 clears it for good.
- R8: With `prio_mode_i`=0, `irq_lo_o` is 0. `irq_hi_o` is bit 7 AND (any source whose flag and enable are both 1 and which is either not a peripheral or has bit 6 set). With the defaults, only the timer (flag bit 2) is a peripheral.
- R9: With `prio_mode_i`=1, a source with flag and enable both 1 drives `irq_hi_o`, gated by bit 7, when its `src_prio_i` bit is 1. It drives `irq_lo_o`, gated by bit 6, when that bit is 0. `src_prio_i` bit 0 = port change, bit 1 = external, bit 2 = timer.
- R10: Neither request output is 1 unless at least one source has its flag and its enable both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tmr_ovf_i | input | 1 | Timer overflow pulse, one cycle |
| ext_evt_i | input | 1 | External event pulse, one cycle |
| port_pins_i | input | 4 | Monitored port pins, asynchronous |
| port_rd_i | input | 1 | Port read strobe, captures the synchronized pins |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| prio_mode_i | input | 1 | Priority mode select |
| src_prio_i | input | 3 | Per-source priority, 1 = high |
| rd_data_o | output | 8 | Register contents |
| irq_hi_o | output | 1 | High-priority request |
| irq_lo_o | output | 1 | Low-priority request |

## Verification
Writes and event pulses show up in the register one edge after they are driven. The request lines follow the register and the mode inputs combinationally, with no added cycle, and a pin change reaches the port-change flag only on the third edge. The bench drives inputs on the falling edge and samples after each rising edge. For the pin path it checks the flag after every one of the three edges, so a stage too many or too few is caught. The routing sweep writes each of the 256 register values once, then steps through both modes and all eight priority patterns. It reads the request lines after a short settle, with no clock edge in between.

// File: rtl/irq_ctl_pkg.sv
package irq_ctl_pkg;
   localparam int REG_W      = 8;
   localparam int NSRC       = 3;
   localparam int SRC_CHG    = 0;
   localparam int SRC_EXT    = 1;
   localparam int SRC_TMR    = 2;
   localparam int EN_BASE    = NSRC;
   localparam int BIT_GLB_LO = 6;
   localparam int BIT_GLB_HI = 7;

   typedef struct packed {
      logic            glb_hi;
      logic            glb_lo;
      logic [NSRC-1:0] en;
      logic [NSRC-1:0] flg;
   } ctl_reg_t;
endpackage

// File: rtl/irq_pin_watch.sv
module irq_pin_watch #(
   parameter int NPINS       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NPINS-1:0] pins_i,
   input  logic             rd_i,
   output logic             mismatch_o
);
   localparam int LAST = SYNC_STAGES - 1;

   if (NPINS < 1) begin : g_bad_pins
      $error("irq_pin_watch: NPINS must be at least 1");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("irq_pin_watch: SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0][NPINS-1:0] stg;
   logic [NPINS-1:0]                  held;

   for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= pins_i;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    held <= '0;
      else if (rd_i) held <= stg[LAST];
   end

   assign mismatch_o = |(stg[LAST] ^ held);
endmodule

// File: rtl/irq_ctl_bit.sv
module irq_ctl_bit #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic wr_i,
   input  logic wd_i,
   output logic q_o
);
   logic nxt;

   always_comb begin
      nxt = wr_i ? wd_i : q_o;
      if (set_i) nxt = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q_o <= RST_VAL;
      else        q_o <= nxt;
   end
endmodule

// File: rtl/irq_route.sv
module irq_route #(
   parameter int               NSRC        = 3,
   parameter logic [NSRC-1:0]  PERIPH_MASK = '0
) (
   input  logic [NSRC-1:0] flg_i,
   input  logic [NSRC-1:0] en_i,
   input  logic            glb_hi_i,
   input  logic            glb_lo_i,
   input  logic            prio_mode_i,
   input  logic [NSRC-1:0] src_prio_i,
   output logic            irq_hi_o,
   output logic            irq_lo_o
);
   if (NSRC < 1) begin : g_bad_nsrc
      $error("irq_route: NSRC must be at least 1");
   end

   logic [NSRC-1:0] req;
   logic [NSRC-1:0] np_pass;

   assign req = flg_i & en_i;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (PERIPH_MASK[i]) begin : g_periph
         assign np_pass[i] = req[i] & glb_lo_i;
      end else begin : g_core
         assign np_pass[i] = req[i];
      end
   end

   logic hi_prio, lo_prio, hi_flat;

   assign hi_prio = glb_hi_i & |(req & src_prio_i);
   assign lo_prio = glb_lo_i & |(req & ~src_prio_i);
   assign hi_flat = glb_hi_i & |np_pass;

   assign irq_hi_o = prio_mode_i ? hi_prio : hi_flat;
   assign irq_lo_o = prio_mode_i & lo_prio;
endmodule

// File: rtl/irq_ctl_reg.sv
module irq_ctl_reg
   import irq_ctl_pkg::*;
#(
   parameter int        NPINS        = 4,
   parameter int        SYNC_STAGES  = 2,
   parameter logic [2:0] PERIPH_MASK = 3'b100,
   parameter logic      CHG_FLAG_RST = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tmr_ovf_i,
   input  logic             ext_evt_i,
   input  logic [NPINS-1:0] port_pins_i,
   input  logic             port_rd_i,
   input  logic             wr_en_i,
   input  logic [7:0]       wr_data_i,
   input  logic             prio_mode_i,
   input  logic [2:0]       src_prio_i,
   output logic [7:0]       rd_data_o,
   output logic             irq_hi_o,
   output logic             irq_lo_o
);
   localparam logic [REG_W-1:0] RST_WORD = {{(REG_W-1){1'b0}}, CHG_FLAG_RST};

   if ($bits(ctl_reg_t) != REG_W) begin : g_bad_layout
      $error("irq_ctl_reg: register layout width mismatch");
   end

   logic             chg_mismatch;
   logic [REG_W-1:0] set_vec;
   ctl_reg_t         cur;

   irq_pin_watch #(
      .NPINS       (NPINS),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_pins (
      .clk        (clk),
      .rst_n      (rst_n),
      .pins_i     (port_pins_i),
      .rd_i       (port_rd_i),
      .mismatch_o (chg_mismatch)
   );

   always_comb begin
      set_vec          = '0;
      set_vec[SRC_CHG] = chg_mismatch;
      set_vec[SRC_EXT] = ext_evt_i;
      set_vec[SRC_TMR] = tmr_ovf_i;
   end

   for (genvar b = 0; b < REG_W; b++) begin : g_bit
      irq_ctl_bit #(
         .RST_VAL (RST_WORD[b])
      ) u_bit (
         .clk   (clk),
         .rst_n (rst_n),
         .set_i (set_vec[b]),
         .wr_i  (wr_en_i),
         .wd_i  (wr_data_i[b]),
         .q_o   (rd_data_o[b])
      );
   end

   assign cur = ctl_reg_t'(rd_data_o);

   irq_route #(
      .NSRC        (NSRC),
      .PERIPH_MASK (PERIPH_MASK)
   ) u_route (
      .flg_i       (cur.flg),
      .en_i        (cur.en),
      .glb_hi_i    (cur.glb_hi),
      .glb_lo_i    (cur.glb_lo),
      .prio_mode_i (prio_mode_i),
      .src_prio_i  (src_prio_i),
      .irq_hi_o    (irq_hi_o),
      .irq_lo_o    (irq_lo_o)
   );
endmodule

// File: rtl/irq_ctl_reg_chk.sv
module irq_ctl_reg_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       tmr_ovf_i,
   input logic       ext_evt_i,
   input logic       wr_en_i,
   input logic [7:0] wr_data_i,
   input logic       prio_mode_i,
   input logic [7:0] rd_data_o,
   input logic       irq_hi_o,
   input logic       irq_lo_o
);
   AST_TMR_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      tmr_ovf_i |=> rd_data_o[2]); // R3
   AST_EXT_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
      ext_evt_i |=> rd_data_o[1]); // R4
   AST_TMR_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_data_o[2] && !wr_en_i) |=> rd_data_o[2]); // R3
   AST_WRITE_LOADS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_i |=> (rd_data_o[7:3] == $past(wr_data_i[7:3]))); // R2
   AST_NO_LO_FLAT: assert property (@(posedge clk) disable iff (!rst_n)
      !prio_mode_i |-> !irq_lo_o); // R8
   AST_REQ_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_hi_o || irq_lo_o) |-> |(rd_data_o[2:0] & rd_data_o[5:3])); // R10
   AST_HI_NEEDS_GLB: assert property (@(posedge clk) disable iff (!rst_n)
      irq_hi_o |-> rd_data_o[7]); // R9
endmodule

bind irq_ctl_reg irq_ctl_reg_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .tmr_ovf_i   (tmr_ovf_i),
   .ext_evt_i   (ext_evt_i),
   .wr_en_i     (wr_en_i),
   .wr_data_i   (wr_data_i),
   .prio_mode_i (prio_mode_i),
   .rd_data_o   (rd_data_o),
   .irq_hi_o    (irq_hi_o),
   .irq_lo_o    (irq_lo_o)
);

// File: tb/sim_irq_ctl_reg.sv
module sim_irq_ctl_reg;
   localparam int CLK_PERIOD = 10;
   localparam logic [2:0] PMASK = 3'b100;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tmr_ovf_i = 1'b0, ext_evt_i = 1'b0, port_rd_i = 1'b0, wr_en_i = 1'b0;
   logic [3:0] port_pins_i = 4'h0;
   logic [7:0] wr_data_i = 8'h00;
   logic       prio_mode_i = 1'b0;
   logic [2:0] src_prio_i = 3'b000;
   logic [7:0] rd_data_o;
   logic       irq_hi_o, irq_lo_o;

   int n_run = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_ctl_reg u0 (
      .clk(clk), .rst_n(rst_n), .tmr_ovf_i(tmr_ovf_i), .ext_evt_i(ext_evt_i),
      .port_pins_i(port_pins_i), .port_rd_i(port_rd_i), .wr_en_i(wr_en_i),
      .wr_data_i(wr_data_i), .prio_mode_i(prio_mode_i), .src_prio_i(src_prio_i),
      .rd_data_o(rd_data_o), .irq_hi_o(irq_hi_o), .irq_lo_o(irq_lo_o)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic wr(input logic [7:0] v);
      wr_en_i = 1'b1; wr_data_i = v;
      tick();
      wr_en_i = 1'b0;
   endtask

   function automatic logic [1:0] exp_irq(input logic [7:0] r, input logic pm, input logic [2:0] sp);
      logic [2:0] rq;
      logic hi, lo;
      rq = r[2:0] & r[5:3];
      if (pm) begin
         hi = r[7] & |(rq & sp);
         lo = r[6] & |(rq & ~sp);
      end else begin
         hi = r[7] & |(rq & (~PMASK | {3{r[6]}}));
         lo = 1'b0;
      end
      return {hi, lo};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: run did not finish actual=hung expected=done");
      if (!done) begin
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 reset", rd_data_o, 8'h00);
      chk("R1 irq", {6'b0, irq_hi_o, irq_lo_o}, 8'h00);
      rst_n = 1'b1;
      tick();
      chk("R1 after release", rd_data_o, 8'h00);

      // R2 write and readback
      wr(8'hF8); chk("R2 enables", rd_data_o, 8'hF8);
      wr(8'h00); chk("R2 clear", rd_data_o, 8'h00);

      // R3 timer flag, enables off
      tmr_ovf_i = 1'b1; tick(); tmr_ovf_i = 1'b0;
      chk("R3 set", rd_data_o, 8'h04);
      tick(); tick();
      chk("R3 hold", rd_data_o, 8'h04);
      wr(8'h00); chk("R3 cleared", rd_data_o, 8'h00);

      // R4 external flag
      ext_evt_i = 1'b1; tick(); ext_evt_i = 1'b0;
      chk("R4 set", rd_data_o, 8'h02);
      tick();
      chk("R4 hold", rd_data_o, 8'h02);
      wr(8'h00); chk("R4 cleared", rd_data_o, 8'h00);

      // R5 set beats write-0
      tmr_ovf_i = 1'b1; ext_evt_i = 1'b1; wr(8'h00);
      tmr_ovf_i = 1'b0; ext_evt_i = 1'b0;
      chk("R5 set wins", rd_data_o, 8'h06);
      wr(8'h00);

      // R6 pin change latency
      port_pins_i = 4'b0100;
      tick(); chk("R6 edge1", rd_data_o, 8'h00);
      tick(); chk("R6 edge2", rd_data_o, 8'h00);
      tick(); chk("R6 edge3", rd_data_o, 8'h01);

      // R7 sticky mismatch
      wr(8'h00); chk("R7 clear ignored", rd_data_o, 8'h01);
      port_rd_i = 1'b1; wr(8'h00); port_rd_i = 1'b0;
      chk("R7 read same cycle as clear", rd_data_o, 8'h01);
      wr(8'h00); chk("R7 clear after read", rd_data_o, 8'h00);
      tick(); chk("R7 stays clear", rd_data_o, 8'h00);
      port_pins_i = 4'b1100;
      tick(); tick(); tick();
      chk("R7 new change", rd_data_o, 8'h01);
      port_rd_i = 1'b1; tick(); port_rd_i = 1'b0;
      chk("R7 after read flag held", rd_data_o, 8'h01);
      wr(8'h00); chk("R7 clear sticks", rd_data_o, 8'h00);

      // R8 R9 R10 sweep
      for (int v = 0; v < 256; v++) begin
         wr(v[7:0]);
         chk("R2 sweep readback", rd_data_o, v[7:0]);
         for (int pm = 0; pm < 2; pm++) begin
            for (int sp = 0; sp < 8; sp++) begin
               prio_mode_i = pm[0]; src_prio_i = sp[2:0];
               #1;
               chk(pm ? "R9 routing" : "R8 routing",
                   {6'b0, irq_hi_o, irq_lo_o},
                   {6'b0, exp_irq(v[7:0], pm[0], sp[2:0])});
               if ((v[2:0] & v[5:3]) == 3'b000)
                  chk("R10 no source", {6'b0, irq_hi_o, irq_lo_o}, 8'h00);
            end
         end
      end

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule